// File: doc/BRIEF.md
# SPI Flash Read Sequencer

This block is the master side of a single read transaction to a serial NOR or NAND flash device over a mode-0 SPI link. A one-cycle start pulse captures an opcode, an address, a flag that says whether the address is sent, and the number of data bytes to fetch. The block lowers chip select once, shifts out the opcode, the address bytes and any dummy bytes that the opcode calls for, and then clocks in the requested data bytes. Chip select is raised only after the last data byte.

SPI is full duplex, so a byte arrives on MISO for every byte sent on MOSI. The block discards the bytes that arrive while the opcode, address and dummy bytes go out. Only the bytes that arrive during the data phase reach the output, which is a byte stream with a valid/ready handshake. If the consumer stalls, the serial clock pauses with SCLK low and chip select still asserted, so no data byte is lost. SCLK runs at the system clock divided by an even parameter `DIV`.

Top module: `spi_flash_rd_seq`

## Requirements
- R1: After reset, cs_no is high, sclk_o is low, busy_o is low and valid_o is low.
- R2: The opcode byte goes out first and every byte is sent MSB first in SPI mode 0. SCLK idles low, MOSI changes only while SCLK is low, and MISO is sampled on the rising SCLK edge.
- R3: When addr_en_i is high, address bytes follow the opcode, most significant byte first. Opcode 0x0C sends four bytes (addr_i[31:0]) and every other opcode sends three bytes (addr_i[23:0]). When addr_en_i is low, no address is sent.
- R4: After the address come dummy bytes of value 0x00. Opcodes 0x0B, 0x0C, 0x4B and 0x5A add one dummy byte, opcode 0xAB adds three, and all other opcodes add none.
- R5: Bytes received during the opcode, address and dummy phases never appear on data_o. The output carries exactly the len_i bytes received in the data phase, in the order they arrived.
- R6: In the data phase MOSI carries 0x00 for each byte read. When len_i is zero, no data phase is run and no SCLK pulse follows the header.
- R7: cs_no stays low without a break from before the first SCLK edge to after the last one, so one transaction forms exactly one frame. SCLK never toggles while cs_no is high.
- R8: busy_o is high from the cycle after an accepted start until the cycle in which cs_no rises. A start pulse that arrives while busy_o is high is ignored.
- R9: SCLK consecutive rising edges are never closer than DIV system clocks. cs_no rises no sooner than DIV system clocks after the last falling SCLK edge.
- R10: While valid_o is high and ready_i is low, valid_o and data_o hold. A stalled consumer pauses SCLK instead of dropping a byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | One-cycle request to begin a read |
| opcode_i | input | 8 | Command byte |
| addr_i | input | 32 | Read address |
| addr_en_i | input | 1 | Send the address phase |
| len_i | input | LEN_W | Number of data bytes to return |
| busy_o | output | 1 | Transaction in progress |
| sclk_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Serial data to the flash |
| cs_no | output | 1 | Chip select, active low |
| miso_i | input | 1 | Serial data from the flash |
| data_o | output | 8 | Returned data byte |
| valid_o | output | 1 | data_o holds a byte |
| ready_i | input | 1 | Consumer accepts data_o |

## Verification
The hardest case to reach from the ports is a data byte that completes while the previous byte is still waiting in the output register. Reaching it needs a consumer that holds ready_i low across several byte times while chip select stays low. The bench holds ready_i low for a long stretch at the start of a multi-byte read. It then checks that no SCLK edge is lost or added, and that every byte still arrives in order. A second stimulus pulses start_i in the middle of a frame. The bench checks that the pulse adds no frame and does not change the header on MOSI.

// File: rtl/spi_rd_pkg.sv
package spi_rd_pkg;
  localparam int ADDR_W     = 32;
  localparam int BIT_CNT_W  = 4;

  localparam logic [7:0] OP_FAST   = 8'h0B;
  localparam logic [7:0] OP_FAST4  = 8'h0C;
  localparam logic [7:0] OP_OTP    = 8'h4B;
  localparam logic [7:0] OP_SFDP   = 8'h5A;
  localparam logic [7:0] OP_SIG    = 8'hAB;

  typedef enum logic [1:0] {ST_IDLE, ST_SHIFT, ST_HOLD, ST_TAIL} seq_st_e;

  function automatic logic [1:0] dummy_cnt(input logic [7:0] op);
    case (op)
      OP_FAST, OP_FAST4, OP_OTP, OP_SFDP: dummy_cnt = 2'd1;
      OP_SIG:                             dummy_cnt = 2'd3;
      default:                            dummy_cnt = 2'd0;
    endcase
  endfunction

  function automatic logic [2:0] addr_cnt(input logic [7:0] op, input logic en);
    if (!en)                addr_cnt = 3'd0;
    else if (op == OP_FAST4) addr_cnt = 3'd4;
    else                    addr_cnt = 3'd3;
  endfunction
endpackage

// File: rtl/spi_rd_tick.sv
module spi_rd_tick #(
  parameter int HALF = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic tick_o
);
  localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (!en_i)         cnt_q <= '0;
    else if (cnt_q == LAST) cnt_q <= '0;
    else                    cnt_q <= cnt_q + 1'b1;
  end

  assign tick_o = en_i && (cnt_q == LAST);

  AST_TICK_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LAST); // R9
  AST_TICK_IDLE_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> cnt_q == '0); // R9
endmodule

// File: rtl/spi_rd_shift.sv
module spi_rd_shift
  import spi_rd_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       load_i,
  input  logic [7:0] load_byte_i,
  input  logic       rise_i,
  input  logic       fall_i,
  input  logic       miso_i,
  output logic       mosi_o,
  output logic [7:0] rx_byte_o,
  output logic       done_o
);
  logic [7:0]           tx_q, rx_q;
  logic [BIT_CNT_W-1:0] bit_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_q  <= '0;
      rx_q  <= '0;
      bit_q <= '0;
    end else if (load_i) begin
      tx_q  <= load_byte_i;
      bit_q <= '0;
    end else begin
      if (rise_i) begin
        rx_q  <= {rx_q[6:0], miso_i};
        bit_q <= bit_q + 1'b1;
      end
      if (fall_i && bit_q != BIT_CNT_W'(8)) tx_q <= {tx_q[6:0], 1'b0};
    end
  end

  assign mosi_o    = tx_q[7];
  assign rx_byte_o = rx_q;
  assign done_o    = (bit_q == BIT_CNT_W'(8));

  AST_BIT_LIMIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_q <= BIT_CNT_W'(8)); // R2
  AST_NO_RISE_AFTER_BYTE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && !load_i |-> !rise_i); // R2
endmodule

// File: rtl/spi_flash_rd_seq.sv
module spi_flash_rd_seq
  import spi_rd_pkg::*;
#(
  parameter int DIV   = 4,
  parameter int LEN_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [7:0]       opcode_i,
  input  logic [31:0]      addr_i,
  input  logic             addr_en_i,
  input  logic [LEN_W-1:0] len_i,
  output logic             busy_o,
  output logic             sclk_o,
  output logic             mosi_o,
  output logic             cs_no,
  input  logic             miso_i,
  output logic [7:0]       data_o,
  output logic             valid_o,
  input  logic             ready_i
);
  localparam int HALF = DIV / 2;

  seq_st_e          st_q;
  logic [7:0]       op_q;
  logic [ADDR_W-1:0] addr_q;
  logic [2:0]       na_q;
  logic [3:0]       hdr_n_q, idx_q;
  logic             data_ph_q, sclk_q, cs_q, tail_q;
  logic [LEN_W-1:0] rem_q;
  logic [7:0]       out_q;
  logic             vld_q;

  logic             tick, rise, fall, done, byte_end;
  logic             out_free, blocked, step, emit, finish, hdr_last, start_acc, load;
  logic [7:0]       load_byte, nxt_hdr, rx_byte;
  logic [3:0]       nxt_idx;
  logic [ADDR_W-1:0] hdr_sh;

  spi_rd_tick #(.HALF(HALF)) u_tick (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (st_q == ST_SHIFT || st_q == ST_TAIL),
    .tick_o(tick)
  );

  assign rise     = (st_q == ST_SHIFT) && tick && !sclk_q;
  assign fall     = (st_q == ST_SHIFT) && tick && sclk_q;
  assign byte_end = fall && done;
  assign out_free = !vld_q || ready_i;
  assign hdr_last = (idx_q == hdr_n_q - 4'd1);
  assign blocked  = byte_end && data_ph_q && !out_free;
  assign step     = (byte_end && !blocked) || (st_q == ST_HOLD && out_free);
  assign emit     = step && data_ph_q;
  assign finish   = step && (data_ph_q ? (rem_q == LEN_W'(1)) : (hdr_last && rem_q == '0));
  assign start_acc = (st_q == ST_IDLE) && start_i;
  assign load     = start_acc || (step && !finish);

  // next header byte: address MSB first, then dummy zeros
  always_comb begin
    nxt_idx = idx_q + 4'd1;
    hdr_sh  = '0;
    nxt_hdr = 8'h00;
    if (nxt_idx <= {1'b0, na_q}) begin
      hdr_sh  = addr_q >> {na_q - nxt_idx[2:0], 3'b000};
      nxt_hdr = hdr_sh[7:0];
    end
  end

  always_comb begin
    if (start_acc)                    load_byte = opcode_i;
    else if (!data_ph_q && !hdr_last) load_byte = nxt_hdr;
    else                              load_byte = 8'h00;
  end

  spi_rd_shift u_shift (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (load),
    .load_byte_i(load_byte),
    .rise_i     (rise),
    .fall_i     (fall),
    .miso_i     (miso_i),
    .mosi_o     (mosi_o),
    .rx_byte_o  (rx_byte),
    .done_o     (done)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= ST_IDLE;
      op_q      <= '0;
      addr_q    <= '0;
      na_q      <= '0;
      hdr_n_q   <= '0;
      idx_q     <= '0;
      data_ph_q <= 1'b0;
      rem_q     <= '0;
      sclk_q    <= 1'b0;
      cs_q      <= 1'b1;
      tail_q    <= 1'b0;
    end else begin
      case (st_q)
        ST_IDLE: if (start_i) begin
          op_q      <= opcode_i;
          addr_q    <= addr_i;
          na_q      <= addr_cnt(opcode_i, addr_en_i);
          hdr_n_q   <= 4'd1 + {1'b0, addr_cnt(opcode_i, addr_en_i)} + {2'b00, dummy_cnt(opcode_i)};
          idx_q     <= '0;
          data_ph_q <= 1'b0;
          rem_q     <= len_i;
          cs_q      <= 1'b0;
          st_q      <= ST_SHIFT;
        end
        ST_SHIFT: begin
          if (rise) sclk_q <= 1'b1;
          if (fall) sclk_q <= 1'b0;
          if (blocked) st_q <= ST_HOLD;
        end
        ST_TAIL: if (tick) begin
          if (tail_q) begin
            cs_q <= 1'b1;
            st_q <= ST_IDLE;
          end else begin
            tail_q <= 1'b1;
          end
        end
        default: ;
      endcase
      if (step) begin
        if (data_ph_q)     rem_q     <= rem_q - 1'b1;
        else if (hdr_last) data_ph_q <= 1'b1;
        else               idx_q     <= idx_q + 4'd1;
        tail_q <= 1'b0;
        st_q   <= finish ? ST_TAIL : ST_SHIFT;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_q <= '0;
      vld_q <= 1'b0;
    end else if (emit) begin
      out_q <= rx_byte;
      vld_q <= 1'b1;
    end else if (ready_i) begin
      vld_q <= 1'b0;
    end
  end

  assign busy_o  = (st_q != ST_IDLE);
  assign sclk_o  = sclk_q;
  assign cs_no   = cs_q;
  assign data_o  = out_q;
  assign valid_o = vld_q;

  AST_SCLK_IN_FRAME: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sclk_o |-> !cs_no); // R7
  AST_MOSI_STABLE_HI: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sclk_o && $past(sclk_o) |-> $stable(mosi_o)); // R2
  AST_CS_NEEDS_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cs_no) |-> $past(start_i)); // R8
  AST_IDLE_CS_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> cs_no); // R8
  AST_OUT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && !ready_i |=> valid_o && $stable(data_o)); // R10
  AST_HOLD_SCLK_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_q == ST_HOLD |-> !sclk_o && !cs_no); // R10
endmodule

// File: tb/spi_flash_rd_seq_tb_top.sv
module spi_flash_rd_seq_tb_top;
  localparam int DIV   = 4;
  localparam int LEN_W = 16;
  localparam int CLK_NS = 8;

  typedef struct packed {
    logic [7:0]  op;
    logic [31:0] addr;
    logic        aen;
    logic [15:0] len;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{8'h03, 32'h0012_3456, 1'b1, 16'd4},
    '{8'h0B, 32'h00AB_CDEF, 1'b1, 16'd3},
    '{8'h0C, 32'h89AB_CDEF, 1'b1, 16'd2},
    '{8'hAB, 32'h0000_0000, 1'b0, 16'd2},
    '{8'h5A, 32'h0000_0010, 1'b1, 16'd1},
    '{8'h4B, 32'h7700_FF00, 1'b1, 16'd2},
    '{8'h9F, 32'h0000_0000, 1'b0, 16'd3},
    '{8'h03, 32'h0001_0203, 1'b1, 16'd0}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0, aen = 1'b0, ready = 1'b1, miso = 1'b0;
  logic [7:0] op = '0;
  logic [31:0] addr = '0;
  logic [LEN_W-1:0] len = '0;
  logic busy, sclk, mosi, cs_n, valid;
  logic [7:0] dout;

  int checks = 0, fails = 0;
  bit finished = 1'b0;

  always #(CLK_NS/2) clk = ~clk;

  spi_flash_rd_seq #(.DIV(DIV), .LEN_W(LEN_W)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .opcode_i(op), .addr_i(addr),
    .addr_en_i(aen), .len_i(len), .busy_o(busy), .sclk_o(sclk), .mosi_o(mosi),
    .cs_no(cs_n), .miso_i(miso), .data_o(dout), .valid_o(valid), .ready_i(ready)
  );

  // flash model
  logic [7:0] mosi_b [64];
  logic [7:0] out_b  [64];
  int bitpos = 0, bytepos = 0, frames = 0, stray = 0, out_n = 0;
  logic [7:0] sr = '0;
  time last_rise = 0, last_fall = 0, min_int = 0, tail_t = 0;

  function automatic logic [7:0] flash_byte(input int n);
    logic [7:0] v;
    v = 8'(n * 29 + 3);
    return v ^ 8'h5A;
  endfunction

  always @(negedge cs_n) begin
    frames++; bitpos = 0; bytepos = 0; min_int = 0; last_rise = 0;
    miso = flash_byte(0)[7];
  end
  always @(posedge sclk) begin
    if (cs_n) stray++;
    if (last_rise != 0 && (min_int == 0 || $time - last_rise < min_int)) min_int = $time - last_rise;
    last_rise = $time;
    sr = {sr[6:0], mosi};
    bitpos++;
    if (bitpos == 8) begin
      if (bytepos < 64) mosi_b[bytepos] = sr;
      bytepos++; bitpos = 0;
    end
  end
  always @(negedge sclk) begin
    if (cs_n) stray++;
    last_fall = $time;
    if (!cs_n) miso = flash_byte(bytepos)[7 - bitpos];
  end
  always @(posedge cs_n) tail_t = $time - last_fall;

  always @(posedge clk) if (rst_n && valid && ready) begin
    if (out_n < 64) out_b[out_n] = dout;
    out_n++;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int exp_dummy(input logic [7:0] o);
    case (o)
      8'h0B, 8'h0C, 8'h4B, 8'h5A: return 1;
      8'hAB: return 3;
      default: return 0;
    endcase
  endfunction

  task automatic run_txn(input vec_t v, input int stall, input bit extra_start);
    int na, nd, hdr, fr0, cyc;
    na  = v.aen ? ((v.op == 8'h0C) ? 4 : 3) : 0;
    nd  = exp_dummy(v.op);
    hdr = 1 + na + nd;
    fr0 = frames;
    out_n = 0; bytepos = 0;
    @(negedge clk);
    op = v.op; addr = v.addr; aen = v.aen; len = v.len; start = 1'b1;
    if (stall > 0) ready = 1'b0;
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1 && cs_n == 1'b0, "R8 busy after start", busy, 1);
    cyc = 0;
    while (busy || !cs_n || cyc <= stall) begin
      @(negedge clk);
      cyc++;
      if (cyc == stall) ready = 1'b1;
      if (extra_start && cyc == 20) begin op = 8'h03; aen = 1'b0; len = 16'd5; start = 1'b1; end
      else start = 1'b0;
      if (!cs_n) chk(busy, "R8 busy while cs low", busy, 1);
    end
    ready = 1'b1;
    repeat (4) @(negedge clk);
    chk(frames == fr0 + 1, "R7 single frame", frames - fr0, 1);
    chk(bytepos == hdr + int'(v.len), "R7 bytes in frame", bytepos, hdr + int'(v.len));
    chk(mosi_b[0] == v.op, "R2 opcode first", mosi_b[0], v.op);
    for (int i = 0; i < na; i++)
      chk(mosi_b[1+i] == v.addr[8*(na-1-i) +: 8], "R3 address byte", mosi_b[1+i], v.addr[8*(na-1-i) +: 8]);
    for (int i = 0; i < nd; i++)
      chk(mosi_b[1+na+i] == 8'h00, "R4 dummy byte", mosi_b[1+na+i], 0);
    for (int i = 0; i < int'(v.len); i++)
      chk(mosi_b[hdr+i] == 8'h00, "R6 data-phase mosi zero", mosi_b[hdr+i], 0);
    chk(out_n == int'(v.len), "R5 output count", out_n, v.len);
    for (int i = 0; i < int'(v.len) && i < out_n; i++)
      chk(out_b[i] == flash_byte(hdr + i), "R5 data byte", out_b[i], flash_byte(hdr + i));
    chk(min_int >= DIV * CLK_NS, "R9 sclk period", int'(min_int), DIV * CLK_NS);
    chk(tail_t >= DIV * CLK_NS, "R9 cs tail", int'(tail_t), DIV * CLK_NS);
    chk(stray == 0, "R7 no sclk outside frame", stray, 0);
    chk(!busy && cs_n && !valid, "R8 idle after frame", busy, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(cs_n == 1'b1, "R1 cs reset", cs_n, 1);
    chk(sclk == 1'b0 && busy == 1'b0 && valid == 1'b0, "R1 outputs reset",
        {sclk, busy, valid}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(cs_n && !sclk && !busy && !valid, "R1 idle after release", {cs_n, sclk, busy, valid}, 4'b1000);
    for (int k = 0; k < NV; k++) run_txn(VECS[k], 0, 1'b0);
    // consumer stall spanning several bytes (R10)
    run_txn('{8'h0B, 32'h0044_5566, 1'b1, 16'd5}, 300, 1'b0);
    // start pulse mid-frame ignored (R8)
    run_txn('{8'h03, 32'h00C0_FFEE, 1'b1, 16'd3}, 0, 1'b1);
    // len zero with signature opcode: header only (R6)
    run_txn('{8'hAB, 32'h0, 1'b0, 16'd0}, 0, 1'b0);
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule